// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Datapath

This block is a small accumulator-style core whose control is a micro-step sequencer. Every instruction passes through a fetch sub-cycle and an execute sub-cycle. An indirect sub-cycle is inserted when the fetched word asks for it. An interrupt sub-cycle is inserted after execute when an enabled request is pending. A 2-bit cycle code always shows which sub-cycle is active. A step counter selects the single register transfer made on each clock.

The core holds a program counter, a memory address register, a memory buffer register, an instruction register and one general register. It drives an address, write data and a write strobe toward a word-wide memory. The memory returns read data combinationally in the same cycle. Instruction words are 16 bits wide: bits [15:12] hold the opcode, bit 11 is the indirect flag and bits [10:0] hold an address. The instruction length is one word.

Top module: `icyc_core`

## Requirements
- R1: While reset is asserted, the program counter and general register read 0, the cycle code reads 00, `halted` is 0 and no memory write is issued.
- R2: The cycle code encodes fetch as 00, indirect as 01, execute as 10 and interrupt as 11. It changes only when a sub-cycle completes.
- R3: Fetch takes three clocks. It reads the word at the program counter and advances the program counter by one. Each instruction then costs 3 clocks of fetch, plus 3 clocks of indirect when bit 11 is set, plus its execute length.
- R4: When bit 11 of the fetched word is set, the indirect sub-cycle reads the word at the address field. The low 11 bits of that word replace the address field, and execute then uses that address.
- R5: Opcode 0001 (add) adds the memory word at the address to the general register, modulo 2^16. It takes three execute clocks.
- R6: Opcode 0010 (increment, skip if zero) writes the memory word plus one back to the same address. If the written value is 0, the program counter advances by one more, which skips the next instruction. It takes four execute clocks and makes exactly one memory write.
- R7: The interrupt sub-cycle is entered only at the end of execute, and only if the request input is high and interrupt enable is set. It takes three clocks, stores the program counter at `SAVE_ADDR` and continues fetching at `ISR_ADDR`.
- R8: A pulse on `ie_set` sets interrupt enable. Entering the interrupt sub-cycle clears it, so a request that stays high is taken only once.
- R9: Opcode 1111 stops sequencing after one execute clock. From then until reset, the program counter, general register, cycle code and memory stay unchanged, whatever happens on `irq` or `ie_set`.
- R10: Every other opcode is a no-op. It finishes execute in one clock and changes neither the general register nor memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq | input | 1 | Interrupt request level |
| ie_set | input | 1 | Pulse that sets interrupt enable |
| mem_addr | output | 11 | Memory address (memory address register) |
| mem_rdata | input | 16 | Memory read data, valid in the same cycle |
| mem_wdata | output | 16 | Memory write data (memory buffer register) |
| mem_we | output | 1 | Memory write strobe, taken on the next rising edge |
| cyc_code | output | 2 | Active sub-cycle code |
| halted | output | 1 | High once a halt opcode has executed |
| pc_o | output | 11 | Program counter |
| r1_o | output | 16 | General register |

## Verification
The assertions assume the memory answers `mem_rdata` combinationally for the address on `mem_addr`. They also assume a write raised on `mem_we` is committed at the next rising edge, so a later read of that address returns the new word. The stimulus uses a behavioural memory in the bench that does exactly this. The bench loads programs only while reset is held. It changes `irq` and `ie_set` just after a clock edge, and it drops `ie_set` after one clock, so every enable is a single-cycle pulse. Operand values are swept over the edges of the 16-bit range, so carry-out, wrap to zero and the skip decision are all exercised.

// File: rtl/icyc_pkg.sv
package icyc_pkg;

  localparam int WORD_W = 16;
  localparam int OP_W   = 4;
  localparam int ADDR_W = WORD_W - OP_W - 1;
  localparam int IND_B  = ADDR_W;
  localparam int STEP_W = 2;

  typedef enum logic [1:0] {
    CYC_FETCH = 2'b00,
    CYC_IND   = 2'b01,
    CYC_EXEC  = 2'b10,
    CYC_INTR  = 2'b11
  } cyc_e;

  localparam logic [OP_W-1:0] OP_ADD  = 4'b0001;
  localparam logic [OP_W-1:0] OP_ISZ  = 4'b0010;
  localparam logic [OP_W-1:0] OP_HALT = 4'b1111;

  // Index of the final micro-step of a sub-cycle.
  function automatic logic [STEP_W-1:0] last_step(cyc_e c, logic [OP_W-1:0] op);
    if (c != CYC_EXEC) return STEP_W'(2);
    case (op)
      OP_ADD:  return STEP_W'(2);
      OP_ISZ:  return STEP_W'(3);
      default: return STEP_W'(0);
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] word_add(logic [WORD_W-1:0] a, logic [WORD_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [WORD_W-1:0] word_inc(logic [WORD_W-1:0] a);
    return a + WORD_W'(1);
  endfunction

  function automatic logic [ADDR_W-1:0] pc_advance(logic [ADDR_W-1:0] pc, int unsigned len);
    return pc + ADDR_W'(len);
  endfunction

endpackage

// File: rtl/icyc_seq.sv
module icyc_seq
  import icyc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op,
  input  logic              fetched_ind,
  input  logic              irq,
  input  logic              ie_set,
  output cyc_e              cyc,
  output logic [STEP_W-1:0] step,
  output logic              halted,
  output logic              ie,
  output logic              ev_sub_end,
  output logic              ev_irq_take
);

  logic [STEP_W-1:0] last;
  logic              halt_hit;
  cyc_e              cyc_nxt;

  assign last        = last_step(cyc, op);
  assign halt_hit    = !halted && (cyc == CYC_EXEC) && (op == OP_HALT);
  assign ev_sub_end  = !halted && !halt_hit && (step == last);
  assign ev_irq_take = ev_sub_end && (cyc == CYC_EXEC) && irq && ie;

  always_comb begin
    case (cyc)
      CYC_FETCH: cyc_nxt = fetched_ind ? CYC_IND : CYC_EXEC;
      CYC_IND:   cyc_nxt = CYC_EXEC;
      CYC_EXEC:  cyc_nxt = (irq && ie) ? CYC_INTR : CYC_FETCH;
      default:   cyc_nxt = CYC_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc    <= CYC_FETCH;
      step   <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (halt_hit) begin
        halted <= 1'b1;
      end else if (ev_sub_end) begin
        cyc  <= cyc_nxt;
        step <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ie <= 1'b0;
    else if (ev_irq_take) ie <= 1'b0;
    else if (ie_set)      ie <= 1'b1;
  end

  assert_step_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    step <= last_step(cyc, op));

  assert_code_moves_at_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_sub_end |=> $stable(cyc));

  assert_take_clears_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_take |=> (cyc == CYC_INTR) && !ie && (step == '0));

  assert_int_only_after_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc != CYC_INTR) && !(ev_sub_end && cyc == CYC_EXEC)) |=> (cyc != CYC_INTR));

  assert_halt_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(cyc) && $stable(step));

endmodule

// File: rtl/icyc_dp.sv
module icyc_dp
  import icyc_pkg::*;
#(
  parameter logic [icyc_pkg::ADDR_W-1:0] SAVE_ADDR = 11'h7F0,
  parameter logic [icyc_pkg::ADDR_W-1:0] ISR_ADDR  = 11'h100,
  parameter int unsigned                 INSN_LEN  = 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_e              cyc,
  input  logic [STEP_W-1:0] step,
  input  logic              halted,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [OP_W-1:0]   op,
  output logic              fetched_ind,
  output logic [ADDR_W-1:0] pc,
  output logic [WORD_W-1:0] r1
);

  logic [ADDR_W-1:0] mar;
  logic [WORD_W-1:0] mbr;
  logic [WORD_W-1:0] ir;
  logic              run;
  logic              mem_op;
  logic              ev_skip;

  assign op          = ir[WORD_W-1 -: OP_W];
  assign fetched_ind = mbr[IND_B];
  assign mem_addr    = mar;
  assign mem_wdata   = mbr;
  assign run         = !halted;
  assign mem_op      = (op == OP_ADD) || (op == OP_ISZ);
  assign mem_we      = run && (((cyc == CYC_EXEC) && (op == OP_ISZ) && (step == 2'd3)) ||
                               ((cyc == CYC_INTR) && (step == 2'd2)));
  assign ev_skip     = run && (cyc == CYC_EXEC) && (op == OP_ISZ) && (step == 2'd3) &&
                       (mbr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc  <= '0;
      r1  <= '0;
      mar <= '0;
      mbr <= '0;
      ir  <= '0;
    end else if (run) begin
      case (cyc)
        CYC_FETCH: begin
          case (step)
            2'd0: mar <= pc;
            2'd1: begin
              mbr <= mem_rdata;
              pc  <= pc_advance(pc, INSN_LEN);
            end
            2'd2: ir <= mbr;
            default: ;
          endcase
        end
        CYC_IND: begin
          case (step)
            2'd0: mar <= ir[ADDR_W-1:0];
            2'd1: mbr <= mem_rdata;
            2'd2: ir[ADDR_W-1:0] <= mbr[ADDR_W-1:0];
            default: ;
          endcase
        end
        CYC_EXEC: begin
          if (mem_op) begin
            case (step)
              2'd0: mar <= ir[ADDR_W-1:0];
              2'd1: mbr <= mem_rdata;
              2'd2: begin
                if (op == OP_ADD) r1  <= word_add(r1, mbr);
                else              mbr <= word_inc(mbr);
              end
              default: if (ev_skip) pc <= pc_advance(pc, INSN_LEN);
            endcase
          end
        end
        default: begin
          case (step)
            2'd0: mbr <= WORD_W'(pc);
            2'd1: begin
              mar <= SAVE_ADDR;
              pc  <= ISR_ADDR;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

  assert_fetch_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc == CYC_FETCH && step == 2'd1) |=> pc == pc_advance($past(pc), INSN_LEN));

  assert_add_result_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc == CYC_EXEC && op == OP_ADD && step == 2'd2) |=> r1 == $past(r1) + $past(mbr));

  assert_write_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ((cyc == CYC_EXEC) && (op == OP_ISZ)) ||
               ((cyc == CYC_INTR) && (mem_addr == SAVE_ADDR)));

  assert_skip_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_skip |=> pc == pc_advance($past(pc), INSN_LEN));

  assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cyc == CYC_INTR && step == 2'd1) |=> (pc == ISR_ADDR) && (mar == SAVE_ADDR));

  assert_no_write_halted_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);

endmodule

// File: rtl/icyc_core.sv
module icyc_core
  import icyc_pkg::*;
#(
  parameter logic [icyc_pkg::ADDR_W-1:0] SAVE_ADDR = 11'h7F0,
  parameter logic [icyc_pkg::ADDR_W-1:0] ISR_ADDR  = 11'h100,
  parameter int unsigned                 INSN_LEN  = 1
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq,
  input  logic              ie_set,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic [1:0]        cyc_code,
  output logic              halted,
  output logic [ADDR_W-1:0] pc_o,
  output logic [WORD_W-1:0] r1_o
);

  cyc_e              cyc;
  logic [STEP_W-1:0] step;
  logic [OP_W-1:0]   op;
  logic              fetched_ind;
  logic              ie;
  logic              ev_sub_end;
  logic              ev_irq_take;

  assign cyc_code = cyc;

  icyc_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .fetched_ind (fetched_ind),
    .irq         (irq),
    .ie_set      (ie_set),
    .cyc         (cyc),
    .step        (step),
    .halted      (halted),
    .ie          (ie),
    .ev_sub_end  (ev_sub_end),
    .ev_irq_take (ev_irq_take)
  );

  icyc_dp #(
    .SAVE_ADDR (SAVE_ADDR),
    .ISR_ADDR  (ISR_ADDR),
    .INSN_LEN  (INSN_LEN)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc         (cyc),
    .step        (step),
    .halted      (halted),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_we      (mem_we),
    .op          (op),
    .fetched_ind (fetched_ind),
    .pc          (pc_o),
    .r1          (r1_o)
  );

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |-> (pc_o == '0) && (r1_o == '0) && (cyc_code == 2'b00) && !halted && !mem_we);

  assert_code_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_sub_end && cyc == CYC_IND) |=> cyc_code == 2'b10);

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_take |-> ie && irq);

endmodule

// File: tb/icyc_core_tb.sv
module icyc_core_tb;
  import icyc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int MEM_N      = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] SAVE_A = 11'h7F0;
  localparam logic [ADDR_W-1:0] ISR_A  = 11'h100;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              irq = 1'b0;
  logic              ie_set = 1'b0;
  logic [ADDR_W-1:0] mem_addr;
  logic [WORD_W-1:0] mem_rdata;
  logic [WORD_W-1:0] mem_wdata;
  logic              mem_we;
  logic [1:0]        cyc_code;
  logic              halted;
  logic [ADDR_W-1:0] pc_o;
  logic [WORD_W-1:0] r1_o;

  logic [WORD_W-1:0] mem [0:MEM_N-1];
  logic              ld_clr = 1'b0;
  logic              ld_we = 1'b0;
  logic [ADDR_W-1:0] ld_a = '0;
  logic [WORD_W-1:0] ld_d = '0;
  int                wcount;
  logic [1:0]        codes [0:63];

  int checks = 0;
  int failures = 0;
  int tick = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  icyc_core #(.SAVE_ADDR(SAVE_A), .ISR_ADDR(ISR_A), .INSN_LEN(1)) u_dut (
    .clk (clk), .rst_n (rst_n), .irq (irq), .ie_set (ie_set),
    .mem_addr (mem_addr), .mem_rdata (mem_rdata), .mem_wdata (mem_wdata),
    .mem_we (mem_we), .cyc_code (cyc_code), .halted (halted),
    .pc_o (pc_o), .r1_o (r1_o)
  );

  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    tick <= tick + 1;
    if (ld_clr) begin
      for (int i = 0; i < MEM_N; i++) mem[i] <= '0;
      wcount <= 0;
    end else if (ld_we) begin
      mem[ld_a] <= ld_d;
    end else if (mem_we) begin
      mem[mem_addr] <= mem_wdata;
      wcount <= wcount + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] insn(input int op, input int ind, input int addr);
    return WORD_W'((op << 12) | (ind << 11) | (addr & 12'h7FF));
  endfunction

  task automatic prog_begin();
    rst_n = 1'b0; irq = 1'b0; ie_set = 1'b0;
    ld_clr = 1'b1;
    @(posedge clk); #1;
    ld_clr = 1'b0;
  endtask

  task automatic poke(input int a, input logic [WORD_W-1:0] d);
    ld_a = ADDR_W'(a); ld_d = d; ld_we = 1'b1;
    @(posedge clk); #1;
    ld_we = 1'b0;
  endtask

  task automatic run(input bit en_ie, input bit irq_v, output int n);
    ie_set = en_ie; irq = irq_v; rst_n = 1'b1; n = 0;
    codes[0] = cyc_code;
    while (!halted && n < 300) begin
      @(posedge clk); #1;
      n++;
      ie_set = 1'b0;
      if (n < 64) codes[n] = cyc_code;
    end
  endtask

  initial begin
    int n;
    logic [WORD_W-1:0] vals [0:7];
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h7FFF; vals[3] = 16'h8000;
    vals[4] = 16'hFFFF; vals[5] = 16'h1234; vals[6] = 16'hFFFE; vals[7] = 16'h00FF;

    // R1: reset state
    prog_begin();
    chk("R1 pc", 32'(pc_o), 0);
    chk("R1 r1", 32'(r1_o), 0);
    chk("R1 code", 32'(cyc_code), 0);
    chk("R1 halted", 32'(halted), 0);
    chk("R1 we", 32'(mem_we), 0);

    // R4 indirect add, R2 code trace, R3 timing
    prog_begin();
    poke(0, insn(1, 1, 12'h040));
    poke(1, insn(15, 0, 0));
    poke(12'h040, 16'hF850);
    poke(12'h050, 16'h2345);
    run(0, 0, n);
    chk("R4 r1 via pointer", 32'(r1_o), 32'h2345);
    chk("R3 clocks indirect add", 32'(n), 3 + 3 + 3 + 3 + 1);
    chk("R3 pc", 32'(pc_o), 2);
    chk("R2 code start", 32'(codes[0]), 0);
    chk("R2 code indirect", 32'(codes[3]), 1);
    chk("R2 code execute", 32'(codes[6]), 2);
    chk("R2 code refetch", 32'(codes[9]), 0);
    chk("R2 code halt exec", 32'(codes[12]), 2);

    // R5 add sweep
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        prog_begin();
        poke(0, insn(1, 0, 12'h030));
        poke(1, insn(1, 0, 12'h031));
        poke(2, insn(15, 0, 0));
        poke(12'h030, vals[i]);
        poke(12'h031, vals[j]);
        run(0, 0, n);
        chk("R5 sum", 32'(r1_o), (int'(vals[i]) + int'(vals[j])) % 65536);
        chk("R5 clocks", 32'(n), 6 + 6 + 4);
      end
    end

    // R6 increment-and-skip sweep
    for (int i = 0; i < 8; i++) begin
      int nv;
      bit skip;
      nv = (int'(vals[i]) + 1) % 65536;
      skip = (nv == 0);
      prog_begin();
      poke(0, insn(2, 0, 12'h020));
      poke(1, insn(1, 0, 12'h021));
      poke(2, insn(15, 0, 0));
      poke(12'h020, vals[i]);
      poke(12'h021, 16'h0ABC);
      run(0, 0, n);
      chk("R6 written word", 32'(mem[12'h020]), nv);
      chk("R6 r1 after skip test", 32'(r1_o), skip ? 0 : 32'h0ABC);
      chk("R6 clocks", 32'(n), 7 + (skip ? 0 : 6) + 4);
      chk("R6 one write", 32'(wcount), 1);
      chk("R6 pc", 32'(pc_o), 3);
    end

    // R10 no-op opcodes
    for (int op = 0; op < 15; op++) begin
      if (op == 1 || op == 2) continue;
      prog_begin();
      poke(0, insn(op, 0, 12'h055));
      poke(1, insn(15, 0, 0));
      poke(12'h055, 16'h5A5A);
      run(0, 0, n);
      chk("R10 clocks", 32'(n), 4 + 4);
      chk("R10 r1", 32'(r1_o), 0);
      chk("R10 memory", 32'(mem[12'h055]), 32'h5A5A);
      chk("R10 no write", 32'(wcount), 0);
    end

    // R7 and R8 interrupt entry with request held high
    prog_begin();
    poke(0, insn(0, 0, 0));
    poke(ISR_A, insn(0, 0, 0));
    poke(ISR_A + 1, insn(15, 0, 0));
    run(1, 1, n);
    chk("R7 clocks", 32'(n), 4 + 3 + 4 + 4);
    chk("R7 saved pc", 32'(mem[SAVE_A]), 1);
    chk("R7 pc in service routine", 32'(pc_o), ISR_A + 2);
    chk("R2 code interrupt", 32'(codes[4]), 3);
    chk("R2 code after interrupt", 32'(codes[7]), 0);
    chk("R8 single entry", 32'(wcount), 1);

    // R7 request without enable is ignored
    prog_begin();
    poke(0, insn(0, 0, 0));
    poke(1, insn(15, 0, 0));
    run(0, 1, n);
    chk("R7 masked clocks", 32'(n), 8);
    chk("R7 masked save slot", 32'(mem[SAVE_A]), 0);
    chk("R7 masked writes", 32'(wcount), 0);

    // R9 halted core stays frozen
    begin
      logic [ADDR_W-1:0] pc_h;
      logic [WORD_W-1:0] r1_h;
      logic [1:0]        code_h;
      pc_h = pc_o; r1_h = r1_o; code_h = cyc_code;
      irq = 1'b1; ie_set = 1'b1;
      repeat (10) @(posedge clk);
      #1;
      chk("R9 halted", 32'(halted), 1);
      chk("R9 pc", 32'(pc_o), 32'(pc_h));
      chk("R9 r1", 32'(r1_o), 32'(r1_h));
      chk("R9 code", 32'(cyc_code), 32'(code_h));
      chk("R9 no writes", 32'(wcount), 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (tick >= 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=below 150000", tick);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule